// File: doc/BRIEF.md
# Four-Stage Pipelined Accumulator Core

A small accumulator processor split into four register-separated stages: fetch, operand read, execute and write-back. Instructions come from an internal program array that is filled through a load port. Operands come from an accumulator and a small register file. When the pipeline is full, one instruction retires per enabled clock. All stage registers move together under a single advance enable. When that enable is low, the whole machine freezes.

Data dependencies are resolved inside the core. An accumulator result is forwarded to the operand-read stage from execute or from write-back, and the younger of the two producers wins. A register read that directly follows a store to the same register costs one bubble. A conditional jump resolves in execute, which means the two sequentially fetched instructions behind it are discarded. A conditional skip removes only the instruction that follows it. Architectural state (the accumulator and the register file) changes only when an instruction leaves the write-back stage. The program counter, the accumulator and the registers are visible on debug outputs, together with a retire strobe.

Top module: `acc_pipe_core`

## Requirements
- R1: While reset is held, and after reset is released but before the first enabled edge, `dbg_pc` is 0, `dbg_acc` is 0, every register in `dbg_regs` is 0 and `dbg_retire` is 0.
- R2: Counting only edges with `adv_en` high, the first instruction fetched from address 0 retires on the 4th edge. Instructions with no jump, skip or store-to-load dependency then retire on consecutive enabled edges.
- R3: On an edge where `adv_en` is low, `dbg_pc`, `dbg_acc` and `dbg_regs` keep their values, and `dbg_retire` is 0 for that cycle.
- R4: An instruction word holds the opcode in bits [12:10], the register index in [9:8] and the immediate in [7:0]. The opcodes are: 0 no-op; 1 acc=imm; 2 acc=acc+reg; 3 acc=acc-reg; 4 reg=acc; 5 jump to imm[3:0] if acc is 0; 6 skip the next instruction if acc is 0; 7 acc=reg. Arithmetic wraps modulo 256. A write on the load port stores `ld_data` at `ld_addr` on that clock edge.
- R5: An instruction that uses the accumulator sees the result of the instruction immediately before it, and of the one before that, with no lost clock.
- R6: An add, subtract or register-load that directly follows a store to the same register retires 2 enabled edges after the store. When the store is older than that, there is no penalty.
- R7: A taken jump discards the two following sequential instructions, which have no effect on state. The instruction at the target retires 3 enabled edges after the jump.
- R8: A jump that is not taken costs nothing, and execution continues at the next address.
- R9: A taken skip discards exactly one instruction, which may itself be a jump, and the instruction after it retires 2 enabled edges after the skip. A skip that is not taken costs nothing.
- R10: `dbg_acc` and `dbg_regs` change only on an edge for which `dbg_retire` was high just before the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the core |
| adv_en | input | 1 | Advance enable for all stages and architectural state |
| ld_we | input | 1 | Program array write strobe |
| ld_addr | input | PC_W (4) | Program array write address |
| ld_data | input | INSTR_W (13) | Instruction word to store |
| dbg_pc | output | PC_W (4) | Fetch program counter |
| dbg_acc | output | DATA_W (8) | Committed accumulator |
| dbg_regs | output | NREG*DATA_W (32) | Committed register file, register k at bits [8k+7:8k] |
| dbg_retire | output | 1 | An instruction commits on the coming edge |

## Verification
The bench runs three programs against an instruction-level model that also predicts the edge on which each instruction retires. The first program mixes back-to-back accumulator chains with register stores read one and two slots later. This separates the forwarding priority between execute and write-back from the one-bubble store-to-read stall. A freeze window in the middle of this run checks that nothing moves while `adv_en` is low. The second program alternates taken and untaken jumps, with state-changing instructions placed in the discarded slots. The third program does the same for skips, including a skipped jump, which shows whether a squash covers one slot or the whole front end.

// File: rtl/acc_pipe_pkg.sv
package acc_pipe_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_NOP = 3'd0,
    OP_LDI = 3'd1,
    OP_ADD = 3'd2,
    OP_SUB = 3'd3,
    OP_STA = 3'd4,
    OP_JZ  = 3'd5,
    OP_SKZ = 3'd6,
    OP_LDR = 3'd7
  } op_e;

  function automatic logic op_reads_reg(op_e op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_LDR);
  endfunction

  function automatic logic op_writes_acc(op_e op);
    return (op == OP_LDI) || (op == OP_ADD) || (op == OP_SUB) || (op == OP_LDR);
  endfunction
endpackage

// File: rtl/acc_pipe_rst_sync.sv
module acc_pipe_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/acc_pipe_prog.sv
module acc_pipe_prog #(
  parameter int DEPTH   = 16,
  parameter int INSTR_W = 13,
  parameter int ADDR_W  = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               we,
  input  logic [ADDR_W-1:0]  waddr,
  input  logic [INSTR_W-1:0] wdata,
  input  logic [ADDR_W-1:0]  raddr,
  output logic [INSTR_W-1:0] rdata
);
  logic [INSTR_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/acc_pipe_hazard.sv
module acc_pipe_hazard
  import acc_pipe_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NREG   = 4,
  parameter int REG_W  = $clog2(NREG)
) (
  input  logic                   rd_vld,
  input  op_e                    rd_op,
  input  logic [REG_W-1:0]       rd_ridx,
  input  logic                   ex_vld,
  input  op_e                    ex_op,
  input  logic [REG_W-1:0]       ex_ridx,
  input  logic [DATA_W-1:0]      ex_acc_res,
  input  logic                   wb_vld,
  input  logic                   wb_acc_we,
  input  logic [DATA_W-1:0]      wb_acc,
  input  logic                   wb_reg_we,
  input  logic [REG_W-1:0]       wb_ridx,
  input  logic [DATA_W-1:0]      wb_reg,
  input  logic [DATA_W-1:0]      arch_acc,
  input  logic [NREG*DATA_W-1:0] arch_regs,
  output logic [DATA_W-1:0]      acc_opnd,
  output logic [DATA_W-1:0]      reg_opnd,
  output logic                   stall
);
  logic ex_acc_hit, wb_acc_hit, wb_reg_hit;

  always_comb begin
    ex_acc_hit = ex_vld && op_writes_acc(ex_op);
    wb_acc_hit = wb_vld && wb_acc_we;
    wb_reg_hit = wb_vld && wb_reg_we && (wb_ridx == rd_ridx);
    // youngest producer first
    if (ex_acc_hit)      acc_opnd = ex_acc_res;
    else if (wb_acc_hit) acc_opnd = wb_acc;
    else                 acc_opnd = arch_acc;
    reg_opnd = wb_reg_hit ? wb_reg : arch_regs[rd_ridx*DATA_W +: DATA_W];
    // a store still in execute is not forwarded to a register read
    stall = rd_vld && op_reads_reg(rd_op) && ex_vld && (ex_op == OP_STA) && (ex_ridx == rd_ridx);
  end
endmodule

// File: rtl/acc_pipe_exec.sv
module acc_pipe_exec
  import acc_pipe_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PC_W   = 4
) (
  input  logic              vld,
  input  op_e               op,
  input  logic [DATA_W-1:0] imm,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] reg_in,
  output logic [DATA_W-1:0] acc_res,
  output logic              acc_we,
  output logic              reg_we,
  output logic              jump,
  output logic              skip,
  output logic [PC_W-1:0]   target
);
  logic acc_zero;

  always_comb begin
    unique case (op)
      OP_LDI:  acc_res = imm;
      OP_ADD:  acc_res = acc_in + reg_in;
      OP_SUB:  acc_res = acc_in - reg_in;
      OP_LDR:  acc_res = reg_in;
      default: acc_res = acc_in;
    endcase
    acc_zero = (acc_in == '0);
    acc_we   = op_writes_acc(op);
    reg_we   = (op == OP_STA);
    jump     = vld && (op == OP_JZ)  && acc_zero;
    skip     = vld && (op == OP_SKZ) && acc_zero;
    target   = imm[PC_W-1:0];
  end
endmodule

// File: rtl/acc_pipe_core.sv
module acc_pipe_core
  import acc_pipe_pkg::*;
#(
  parameter int  DATA_W     = 8,
  parameter int  PROG_DEPTH = 16,
  parameter int  NREG       = 4,
  localparam int PC_W       = $clog2(PROG_DEPTH),
  localparam int REG_W      = $clog2(NREG),
  localparam int INSTR_W    = OP_W + REG_W + DATA_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   adv_en,
  input  logic                   ld_we,
  input  logic [PC_W-1:0]        ld_addr,
  input  logic [INSTR_W-1:0]     ld_data,
  output logic [PC_W-1:0]        dbg_pc,
  output logic [DATA_W-1:0]      dbg_acc,
  output logic [NREG*DATA_W-1:0] dbg_regs,
  output logic                   dbg_retire
);
  logic rst_ni;

  // architectural state
  logic [PC_W-1:0]        pc_q, pc_d;
  logic [DATA_W-1:0]      acc_q, acc_d;
  logic [NREG*DATA_W-1:0] regs_q, regs_d;
  // fetch -> operand read
  logic                   f_vld_q, f_vld_d;
  logic [INSTR_W-1:0]     f_ins_q, f_ins_d;
  // operand read -> execute
  logic                   o_vld_q, o_vld_d;
  op_e                    o_op_q, o_op_d;
  logic [REG_W-1:0]       o_ridx_q, o_ridx_d;
  logic [DATA_W-1:0]      o_imm_q, o_imm_d, o_acc_q, o_acc_d, o_reg_q, o_reg_d;
  // execute -> write-back
  logic                   w_vld_q, w_vld_d, w_acc_we_q, w_acc_we_d, w_reg_we_q, w_reg_we_d;
  logic [DATA_W-1:0]      w_acc_q, w_acc_d, w_reg_q, w_reg_d;
  logic [REG_W-1:0]       w_ridx_q, w_ridx_d;

  logic [INSTR_W-1:0]     prog_rd;
  op_e                    f_op;
  logic [REG_W-1:0]       f_ridx;
  logic [DATA_W-1:0]      fw_acc, fw_reg, x_acc;
  logic                   stall, x_acc_we, x_reg_we, x_jump, x_skip;
  logic [PC_W-1:0]        x_target;

  acc_pipe_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ni));

  acc_pipe_prog #(.DEPTH(PROG_DEPTH), .INSTR_W(INSTR_W), .ADDR_W(PC_W)) u_prog (
    .clk(clk), .we(ld_we), .waddr(ld_addr), .wdata(ld_data), .raddr(pc_q), .rdata(prog_rd)
  );

  assign f_op   = op_e'(f_ins_q[INSTR_W-1 -: OP_W]);
  assign f_ridx = f_ins_q[DATA_W +: REG_W];

  acc_pipe_hazard #(.DATA_W(DATA_W), .NREG(NREG), .REG_W(REG_W)) u_haz (
    .rd_vld(f_vld_q), .rd_op(f_op), .rd_ridx(f_ridx),
    .ex_vld(o_vld_q), .ex_op(o_op_q), .ex_ridx(o_ridx_q), .ex_acc_res(x_acc),
    .wb_vld(w_vld_q), .wb_acc_we(w_acc_we_q), .wb_acc(w_acc_q),
    .wb_reg_we(w_reg_we_q), .wb_ridx(w_ridx_q), .wb_reg(w_reg_q),
    .arch_acc(acc_q), .arch_regs(regs_q),
    .acc_opnd(fw_acc), .reg_opnd(fw_reg), .stall(stall)
  );

  acc_pipe_exec #(.DATA_W(DATA_W), .PC_W(PC_W)) u_exec (
    .vld(o_vld_q), .op(o_op_q), .imm(o_imm_q), .acc_in(o_acc_q), .reg_in(o_reg_q),
    .acc_res(x_acc), .acc_we(x_acc_we), .reg_we(x_reg_we),
    .jump(x_jump), .skip(x_skip), .target(x_target)
  );

  always_comb begin
    pc_d = pc_q;  acc_d = acc_q;  regs_d = regs_q;
    f_vld_d = f_vld_q;  f_ins_d = f_ins_q;
    o_vld_d = o_vld_q;  o_op_d = o_op_q;  o_ridx_d = o_ridx_q;
    o_imm_d = o_imm_q;  o_acc_d = o_acc_q;  o_reg_d = o_reg_q;
    w_vld_d = w_vld_q;  w_acc_we_d = w_acc_we_q;  w_acc_d = w_acc_q;
    w_reg_we_d = w_reg_we_q;  w_ridx_d = w_ridx_q;  w_reg_d = w_reg_q;
    if (adv_en) begin
      // write-back: the only place architectural state changes
      if (w_vld_q && w_acc_we_q) acc_d = w_acc_q;
      if (w_vld_q && w_reg_we_q) regs_d[w_ridx_q*DATA_W +: DATA_W] = w_reg_q;
      // execute -> write-back
      w_vld_d = o_vld_q;  w_acc_we_d = x_acc_we;  w_acc_d = x_acc;
      w_reg_we_d = x_reg_we;  w_ridx_d = o_ridx_q;  w_reg_d = o_acc_q;
      // operand read -> execute
      if (stall) begin
        o_vld_d = 1'b0;
      end else begin
        o_vld_d  = f_vld_q && !x_jump && !x_skip;
        o_op_d   = f_op;
        o_ridx_d = f_ridx;
        o_imm_d  = f_ins_q[DATA_W-1:0];
        o_acc_d  = fw_acc;
        o_reg_d  = fw_reg;
      end
      // fetch
      if (x_jump) begin
        f_vld_d = 1'b0;
        pc_d    = x_target;
      end else if (!stall) begin
        f_vld_d = 1'b1;
        f_ins_d = prog_rd;
        pc_d    = pc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= '0;
      acc_q   <= '0;
      regs_q  <= '0;
      f_vld_q <= 1'b0;
      o_vld_q <= 1'b0;
      w_vld_q <= 1'b0;
    end else begin
      pc_q    <= pc_d;
      acc_q   <= acc_d;
      regs_q  <= regs_d;
      f_vld_q <= f_vld_d;
      o_vld_q <= o_vld_d;
      w_vld_q <= w_vld_d;
    end
  end

  always_ff @(posedge clk) begin
    f_ins_q    <= f_ins_d;
    o_op_q     <= o_op_d;
    o_ridx_q   <= o_ridx_d;
    o_imm_q    <= o_imm_d;
    o_acc_q    <= o_acc_d;
    o_reg_q    <= o_reg_d;
    w_acc_we_q <= w_acc_we_d;
    w_acc_q    <= w_acc_d;
    w_reg_we_q <= w_reg_we_d;
    w_ridx_q   <= w_ridx_d;
    w_reg_q    <= w_reg_d;
  end

  assign dbg_pc     = pc_q;
  assign dbg_acc    = acc_q;
  assign dbg_regs   = regs_q;
  assign dbg_retire = w_vld_q && adv_en;
endmodule

// File: rtl/acc_pipe_chk.sv
module acc_pipe_chk #(
  parameter int PC_W   = 4,
  parameter int DATA_W = 8,
  parameter int NREG   = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   adv_en,
  input logic [PC_W-1:0]        pc,
  input logic [DATA_W-1:0]      acc,
  input logic [NREG*DATA_W-1:0] regs,
  input logic                   retire,
  input logic                   stall,
  input logic                   jump,
  input logic                   skip,
  input logic                   f_vld,
  input logic                   o_vld
);
  a_r3_freeze_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_en |=> $stable(pc) && $stable(acc) && $stable(regs));

  a_r10_commit_only_at_retire: assert property (@(posedge clk) disable iff (!rst_n)
    !retire |=> $stable(acc) && $stable(regs));

  a_r6_stall_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_en && stall) |=> !o_vld && $stable(pc));

  a_r6_hazard_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stall, jump, skip}));

  a_r7_jump_flushes_front: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_en && jump) |=> !f_vld && !o_vld);

  a_r9_skip_one_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_en && skip) |=> !o_vld && f_vld);
endmodule

bind acc_pipe_core acc_pipe_chk #(.PC_W(PC_W), .DATA_W(DATA_W), .NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .adv_en(adv_en), .pc(dbg_pc), .acc(dbg_acc), .regs(dbg_regs),
  .retire(dbg_retire), .stall(stall), .jump(x_jump), .skip(x_skip),
  .f_vld(f_vld_q), .o_vld(o_vld_q)
);

// File: tb/acc_pipe_core_bench.sv
`timescale 1ns/1ps
module acc_pipe_core_bench;
  logic        clk = 1'b0;
  logic        rst_n, adv_en, ld_we;
  logic [3:0]  ld_addr;
  logic [12:0] ld_data;
  logic [3:0]  dbg_pc;
  logic [7:0]  dbg_acc;
  logic [31:0] dbg_regs;
  logic        dbg_retire;

  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  acc_pipe_core u_acc_pipe_core (
    .clk(clk), .rst_n(rst_n), .adv_en(adv_en), .ld_we(ld_we), .ld_addr(ld_addr),
    .ld_data(ld_data), .dbg_pc(dbg_pc), .dbg_acc(dbg_acc), .dbg_regs(dbg_regs),
    .dbg_retire(dbg_retire)
  );

  // instruction-level reference
  logic [12:0] mprog [16];
  int          mpc;
  logic [7:0]  macc;
  logic [7:0]  mreg [4];

  function automatic logic [12:0] enc(int op, int r, int imm);
    return {3'(op), 2'(r), 8'(imm)};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit reads_reg(logic [2:0] op);
    return op == 3'd2 || op == 3'd3 || op == 3'd7;
  endfunction

  // executes one instruction; returns edges until the next retire and its cause
  task automatic model_step(output int gap, output string tag);
    logic [12:0] ins = mprog[mpc];
    logic [2:0]  op  = ins[12:10];
    logic [1:0]  r   = ins[9:8];
    logic [7:0]  imm = ins[7:0];
    logic [12:0] nins;
    int nxt = (mpc + 1) % 16;
    gap = 1; tag = "R2";
    case (op)
      3'd1: begin macc = imm; tag = "R5"; end
      3'd2: begin macc = macc + mreg[r]; tag = "R5"; end
      3'd3: begin macc = macc - mreg[r]; tag = "R5"; end
      3'd7: begin macc = mreg[r]; tag = "R5"; end
      3'd4: begin
        mreg[r] = macc;
        nins = mprog[nxt];
        if (reads_reg(nins[12:10]) && nins[9:8] == r) begin gap = 2; tag = "R6"; end
      end
      3'd5: if (macc == 0) begin nxt = imm[3:0]; gap = 3; tag = "R7"; end else tag = "R8";
      3'd6: if (macc == 0) begin nxt = (mpc + 2) % 16; gap = 2; tag = "R9"; end else tag = "R9";
      default: ;
    endcase
    mpc = nxt;
  endtask

  task automatic run_prog(input int ncyc, input int hold_at);
    int edges = 0, exp_edge = 4, gap;
    bit pend = 0;
    string tag = "R2", ntag;
    logic [3:0] prev_pc;
    adv_en = 0; ld_we = 0; rst_n = 0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      ld_we = 1; ld_addr = 4'(i); ld_data = mprog[i];
      @(negedge clk);
    end
    ld_we = 0;
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(dbg_pc == 0, "R1", "pc", dbg_pc, 0);
    check(dbg_acc == 0, "R1", "acc", dbg_acc, 0);
    check(dbg_regs == 0, "R1", "regs", dbg_regs, 0);
    check(dbg_retire == 0, "R1", "retire", dbg_retire, 0);
    mpc = 0; macc = 0;
    for (int r = 0; r < 4; r++) mreg[r] = 0;
    adv_en = 1;
    for (int cyc = 0; cyc < ncyc; cyc++) begin
      prev_pc = dbg_pc;
      @(posedge clk);
      if (adv_en) edges++;
      @(negedge clk);
      if (!adv_en) check(dbg_pc == prev_pc, "R3", "pc held", dbg_pc, prev_pc);
      if (pend) begin
        check(edges == exp_edge, tag, "retire edge", edges, exp_edge);
        model_step(gap, ntag);
        exp_edge += gap;
        tag = ntag;
      end
      // R4 semantics on retire edges, R10 otherwise (state unchanged)
      check(dbg_acc == macc, pend ? "R4" : "R10", "acc", dbg_acc, macc);
      for (int r = 0; r < 4; r++)
        check(dbg_regs[r*8 +: 8] == mreg[r], pend ? "R4" : "R10", "reg", dbg_regs[r*8 +: 8], mreg[r]);
      adv_en = !(hold_at >= 0 && cyc >= hold_at && cyc < hold_at + 3);
      #1;
      pend = dbg_retire;
      if (!adv_en) check(dbg_retire == 0, "R3", "retire while frozen", dbg_retire, 0);
    end
  endtask

  initial begin
    // forwarding chains and store-to-read distances (R5, R6), freeze window (R3)
    for (int i = 0; i < 16; i++) mprog[i] = enc(0, 0, 0);
    mprog[0]  = enc(1, 0, 3);
    mprog[1]  = enc(4, 1, 0);
    mprog[2]  = enc(1, 0, 10);
    mprog[3]  = enc(2, 1, 0);
    mprog[4]  = enc(2, 1, 0);
    mprog[5]  = enc(4, 2, 0);
    mprog[6]  = enc(3, 2, 0);
    mprog[7]  = enc(7, 1, 0);
    mprog[8]  = enc(4, 3, 0);
    mprog[9]  = enc(0, 3, 0);
    mprog[10] = enc(2, 3, 0);
    mprog[11] = enc(3, 0, 0);
    mprog[12] = enc(4, 0, 0);
    mprog[13] = enc(2, 0, 0);
    run_prog(60, 15);

    // taken and untaken jumps with effects in the flushed slots (R7, R8)
    for (int i = 0; i < 16; i++) mprog[i] = enc(0, 0, 0);
    mprog[0]  = enc(1, 0, 0);
    mprog[1]  = enc(5, 0, 5);
    mprog[2]  = enc(1, 0, 9);
    mprog[3]  = enc(4, 1, 0);
    mprog[4]  = enc(1, 0, 7);
    mprog[5]  = enc(1, 0, 1);
    mprog[6]  = enc(5, 0, 0);
    mprog[7]  = enc(4, 2, 0);
    mprog[8]  = enc(3, 2, 0);
    mprog[9]  = enc(5, 0, 12);
    mprog[10] = enc(1, 0, 85);
    mprog[11] = enc(4, 3, 0);
    mprog[12] = enc(1, 0, 4);
    mprog[13] = enc(4, 3, 0);
    mprog[14] = enc(1, 0, 0);
    mprog[15] = enc(5, 0, 2);
    run_prog(70, -1);

    // taken and untaken skips, including a skipped jump (R9)
    for (int i = 0; i < 16; i++) mprog[i] = enc(0, 0, 0);
    mprog[0]  = enc(1, 0, 0);
    mprog[1]  = enc(6, 0, 0);
    mprog[2]  = enc(1, 0, 68);
    mprog[3]  = enc(4, 1, 0);
    mprog[4]  = enc(1, 0, 2);
    mprog[5]  = enc(6, 0, 0);
    mprog[6]  = enc(4, 2, 0);
    mprog[7]  = enc(1, 0, 0);
    mprog[8]  = enc(6, 0, 0);
    mprog[9]  = enc(5, 0, 0);
    mprog[10] = enc(1, 0, 6);
    mprog[11] = enc(4, 3, 0);
    mprog[12] = enc(6, 0, 0);
    mprog[13] = enc(1, 0, 0);
    run_prog(60, -1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule